// File: doc/BRIEF.md
# Interrupt Status and Mask Controller

This block keeps the interrupt state of a network controller. Fifteen sticky status flags capture single-cycle event pulses from the transmit and receive DMA engines. A fifteen-bit enable register chooses which flags may drive one level-sensitive interrupt request toward the host. Software reads both registers over a simple 32-bit register bus. It acknowledges a flag by writing a one to that flag's position in the status register.

Two flags report that an engine fetched a descriptor the host still owns: transmit queue empty at bit 7 and receive queue empty at bit 2. Each clears by itself when the driver strobes the matching "queued" command. Two other flags are qualified at the input. The receive CRC error flag is ignored while monitor mode is on. The transmit-done flag only counts when that frame requested an interrupt.

Top module: `irq_ctrl`

## Requirements
- R1: While rst_ni is low, the status register, the enable register and irq_o are all zero.
- R2: An evt_i pulse on any bit other than 4 and 5 sets the matching status bit at the next clock edge. The bit then stays set until it is cleared.
- R3: A bus write to offset 0x04 clears every status bit whose wdata bit is 1 and leaves every bit whose wdata bit is 0 unchanged.
- R4: When a set event and a clear (by write or by strobe) hit the same status bit in the same cycle, the bit ends up set.
- R5: evt_i[4] (receive CRC error) sets status bit 4 only while mon_mode_i is low.
- R6: evt_i[5] (transmit done) sets status bit 5 only while tx_frame_irq_i is high.
- R7: A tx_queued_i pulse clears status bit 7, and a rx_queued_i pulse clears status bit 2. Neither strobe touches any other bit.
- R8: A write to offset 0x08 loads wdata[14:0] into the enable register. Reads at 0x04 and 0x08 return status and enable in bits 14:0, with bits 31:15 zero. Any other offset reads zero.
- R9: irq_o is a register. One cycle after any status bit and its enable bit are both 1, it goes high, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 15 | Event pulses, one per status bit |
| mon_mode_i | input | 1 | Monitor mode, blocks the CRC error flag |
| tx_frame_irq_i | input | 1 | Per-frame interrupt request that comes with evt_i[5] |
| tx_queued_i | input | 1 | Transmit-queued command strobe |
| rx_queued_i | input | 1 | Receive-queued command strobe |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | 8 | Byte offset |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational on offset |
| irq_o | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check four things:
- irq_o follows the registered AND-OR of status and enable.
- Plain events always land in status.
- A gated CRC error or a transmit-done without a frame request never raises its flag.
- A queued strobe with no competing event clears its flag, and the upper read bits stay zero.

Only the bench scenarios show the write-one-to-clear behaviour, where zero bits must be ignored. They also cover set-over-clear priority, readback of the enable register, and the reset values. The bench model tracks every register on each clock and compares irq_o and the read data.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned SRC_W  = 15;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned ADDR_W = 8;

  localparam int unsigned B_RX_QEMPTY = 2;
  localparam int unsigned B_RX_CRC    = 4;
  localparam int unsigned B_TX_DONE   = 5;
  localparam int unsigned B_TX_QEMPTY = 7;

  typedef logic [SRC_W-1:0] src_vec_t;
endpackage

// File: rtl/irq_evt_qual.sv
module irq_evt_qual
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic [W-1:0] evt_i,
  input  logic         mon_mode_i,
  input  logic         tx_frame_irq_i,
  output logic [W-1:0] set_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == B_RX_CRC) begin : g_crc
      assign set_o[i] = evt_i[i] & ~mon_mode_i;
    end else if (i == B_TX_DONE) begin : g_txd
      assign set_o[i] = evt_i[i] & tx_frame_irq_i;
    end else begin : g_plain
      assign set_o[i] = evt_i[i];
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] sw_clr_i,
  input  logic         tx_queued_i,
  input  logic         rx_queued_i,
  output logic [W-1:0] status_o
);
  logic [W-1:0] auto_clr;
  logic [W-1:0] status_q;

  for (genvar i = 0; i < W; i++) begin : g_clr
    if (i == B_TX_QEMPTY) begin : g_txq
      assign auto_clr[i] = tx_queued_i;
    end else if (i == B_RX_QEMPTY) begin : g_rxq
      assign auto_clr[i] = rx_queued_i;
    end else begin : g_none
      assign auto_clr[i] = 1'b0;
    end
  end

  // set dominates any clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~(sw_clr_i | auto_clr)) | set_i;
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mask_q <= '0;
    else if (we_i) mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned W = SRC_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] status_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_i & mask_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned         W        = SRC_W,
  parameter int unsigned         AW       = ADDR_W,
  parameter int unsigned         DW       = DATA_W,
  parameter logic [ADDR_W-1:0]   STAT_OFS = 8'h04,
  parameter logic [ADDR_W-1:0]   MASK_OFS = 8'h08
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  evt_i,
  input  logic          mon_mode_i,
  input  logic          tx_frame_irq_i,
  input  logic          tx_queued_i,
  input  logic          rx_queued_i,
  input  logic          bus_sel_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  localparam int unsigned PAD_W = DW - W;

  logic [W-1:0] set_vec;
  logic [W-1:0] sw_clr;
  logic [W-1:0] status_q;
  logic [W-1:0] mask_q;
  logic         wr_stat;
  logic         wr_mask;

  assign wr_stat = bus_sel_i & bus_we_i & (bus_addr_i == STAT_OFS[AW-1:0]);
  assign wr_mask = bus_sel_i & bus_we_i & (bus_addr_i == MASK_OFS[AW-1:0]);
  assign sw_clr  = wr_stat ? bus_wdata_i[W-1:0] : '0;

  irq_evt_qual #(.W(W)) u_qual (
    .evt_i          (evt_i),
    .mon_mode_i     (mon_mode_i),
    .tx_frame_irq_i (tx_frame_irq_i),
    .set_o          (set_vec)
  );

  irq_status_reg #(.W(W)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_vec),
    .sw_clr_i    (sw_clr),
    .tx_queued_i (tx_queued_i),
    .rx_queued_i (rx_queued_i),
    .status_o    (status_q)
  );

  irq_mask_reg #(.W(W)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_mask),
    .wdata_i (bus_wdata_i[W-1:0]),
    .mask_o  (mask_q)
  );

  irq_req_gen #(.W(W)) u_req (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .status_i (status_q),
    .mask_i   (mask_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    if (bus_addr_i == STAT_OFS[AW-1:0])      bus_rdata_o = {{PAD_W{1'b0}}, status_q};
    else if (bus_addr_i == MASK_OFS[AW-1:0]) bus_rdata_o = {{PAD_W{1'b0}}, mask_q};
    else                                     bus_rdata_o = '0;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
  import irq_ctrl_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SRC_W-1:0]  evt_i,
  input logic              mon_mode_i,
  input logic              tx_frame_irq_i,
  input logic              tx_queued_i,
  input logic              rx_queued_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              irq_o,
  input logic [SRC_W-1:0]  status_q,
  input logic [SRC_W-1:0]  mask_q
);
  localparam logic [SRC_W-1:0] PLAIN = ~(SRC_W'(1) << B_RX_CRC | SRC_W'(1) << B_TX_DONE);

  assert_reset_quiet_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (irq_o == 1'b0 && status_q == '0 && mask_q == '0));

  assert_plain_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    |(evt_i & PLAIN) |=> ((status_q & $past(evt_i & PLAIN)) == $past(evt_i & PLAIN)));

  assert_crc_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mon_mode_i && !status_q[B_RX_CRC]) |=> !status_q[B_RX_CRC]);

  assert_txdone_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_frame_irq_i && !status_q[B_TX_DONE]) |=> !status_q[B_TX_DONE]);

  assert_txq_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_queued_i && !evt_i[B_TX_QEMPTY]) |=> !status_q[B_TX_QEMPTY]);

  assert_rxq_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_queued_i && !evt_i[B_RX_QEMPTY]) |=> !status_q[B_RX_QEMPTY]);

  assert_upper_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:SRC_W] == '0);

  assert_irq_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_q & mask_q))));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .evt_i          (evt_i),
  .mon_mode_i     (mon_mode_i),
  .tx_frame_irq_i (tx_frame_irq_i),
  .tx_queued_i    (tx_queued_i),
  .rx_queued_i    (rx_queued_i),
  .bus_rdata_o    (bus_rdata_o),
  .irq_o          (irq_o),
  .status_q       (status_q),
  .mask_q         (mask_q)
);

// File: tb/irq_ctrl_tb.sv
module irq_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_STAT = 8'h04;
  localparam logic [7:0] A_MASK = 8'h08;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] evt = '0;
  logic        mon = 1'b0, txf = 1'b0, txq = 1'b0, rxq = 1'b0;
  logic        sel = 1'b0, we = 1'b0;
  logic [7:0]  addr = A_STAT;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  // reference state
  logic [14:0] m_stat = '0, m_mask = '0;
  logic        m_irq = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .mon_mode_i(mon),
    .tx_frame_irq_i(txf), .tx_queued_i(txq), .rx_queued_i(rxq),
    .bus_sel_i(sel), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_irq = 1'b0;
    end else begin
      logic [14:0] s, c;
      m_irq = (m_stat & m_mask) != 0;
      s = evt;
      if (mon)  s[4] = 1'b0;
      if (!txf) s[5] = 1'b0;
      c = '0;
      if (sel && we && addr == A_STAT) c = wdata[14:0];
      if (txq) c[7] = 1'b1;
      if (rxq) c[2] = 1'b1;
      m_stat = (m_stat & ~c) | s;
      if (sel && we && addr == A_MASK) m_mask = wdata[14:0];
    end
  end

  function automatic logic [31:0] m_read(logic [7:0] a);
    if (a == A_STAT) return {17'b0, m_stat};
    if (a == A_MASK) return {17'b0, m_mask};
    return '0;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic compare();
    chk({cur_req, " irq R9"}, {31'b0, irq}, {31'b0, m_irq});
    chk({cur_req, " rdata"}, rdata, m_read(addr));
  endtask

  // one clock: inputs already driven, sample after the edge, drop pulses
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    compare();
    evt = '0; txq = 1'b0; rxq = 1'b0; sel = 1'b0; we = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
  endtask

  task automatic peek(logic [7:0] a);
    addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1 reset values
    repeat (2) @(negedge clk);
    peek(A_STAT); chk("R1 status", rdata, 32'h0);
    peek(A_MASK); chk("R1 mask", rdata, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 mask load and readback
    cur_req = "R8";
    wr(A_MASK, 32'hFFFF_0000); tick();
    peek(A_MASK); chk("R8 mask upper", rdata, 32'h0000_0000);
    wr(A_MASK, 32'hFFFF_FFFF); tick();
    peek(A_MASK); chk("R8 mask full", rdata, 32'h0000_7FFF);
    peek(8'h0C); chk("R8 other offset", rdata, 32'h0);
    wr(A_MASK, 32'h0); tick();

    // R2 events set sticky bits; R9 gated by mask
    cur_req = "R2";
    addr = A_STAT;
    evt = 15'h0001; tick();
    chk("R2 bit0", rdata, 32'h1);
    chk("R9 masked off", {31'b0, irq}, 32'h0);
    evt = 15'h4080; tick();
    chk("R2 bits14,7", rdata, 32'h4081);
    tick();
    chk("R2 sticky", rdata, 32'h4081);

    cur_req = "R9";
    wr(A_MASK, 32'h0000_4000); tick();
    chk("R9 not yet", {31'b0, irq}, 32'h0);
    tick();
    chk("R9 one cycle later", {31'b0, irq}, 32'h1);
    addr = A_STAT;

    // R3 write-one-to-clear
    cur_req = "R3";
    wr(A_STAT, 32'h0000_0000); tick();
    chk("R3 zero write ignored", rdata, 32'h4081);
    wr(A_STAT, 32'h0000_4001); tick();
    chk("R3 cleared", rdata, 32'h0080);
    tick();
    chk("R9 dropped", {31'b0, irq}, 32'h0);

    // R4 set wins over clear
    cur_req = "R4";
    evt = 15'h0002; wr(A_STAT, 32'h0000_0002); tick();
    chk("R4 set over write", rdata, 32'h0082);
    evt = 15'h0080; txq = 1'b1; tick();
    chk("R4 set over strobe", rdata, 32'h0082);

    // R7 queued strobes
    cur_req = "R7";
    evt = 15'h0004; tick();
    chk("R7 rx qempty set", rdata, 32'h0086);
    txq = 1'b1; tick();
    chk("R7 txq clears 7 only", rdata, 32'h0006);
    rxq = 1'b1; tick();
    chk("R7 rxq clears 2 only", rdata, 32'h0002);

    // R5 CRC error gated by monitor mode
    cur_req = "R5";
    mon = 1'b1; evt = 15'h0010; tick();
    chk("R5 blocked", rdata, 32'h0002);
    mon = 1'b0; evt = 15'h0010; tick();
    chk("R5 accepted", rdata, 32'h0012);

    // R6 tx done gated by frame flag
    cur_req = "R6";
    txf = 1'b0; evt = 15'h0020; tick();
    chk("R6 blocked", rdata, 32'h0012);
    txf = 1'b1; evt = 15'h0020; tick();
    chk("R6 accepted", rdata, 32'h0032);
    txf = 1'b0;

    // R9 with several enables
    cur_req = "R9";
    wr(A_MASK, 32'h0000_0020); tick();
    addr = A_STAT; tick();
    chk("R9 bit5 enabled", {31'b0, irq}, 32'h1);
    wr(A_STAT, 32'h0000_7FFF); tick();
    tick();
    chk("R9 all cleared", {31'b0, irq}, 32'h0);
    chk("R3 all cleared", rdata, 32'h0);

    repeat (3) tick();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule